// File: doc/BRIEF.md
# Priority-level interrupt aggregator

This block collects level-sensitive requests from thirteen peripheral sources into one 32-bit status register. A 32-bit mask register sits beside it. Each source owns a fixed bit in the status word and belongs to one of three processor priority groups (3, 5 or 6). A status bit counts as pending when it is set and its mask bit is set too. The block reports the highest group level that has a pending bit as a three-bit interrupt priority level, together with the autovector number for that level.

Host software reads and writes status and mask as whole words on a simple register port. A status write replaces every bit. A separate control strobe from the disk-interface logic can also force the SCSI DMA status bit on or off. Source bits follow the edges of their request lines: a rising request sets the bit and a falling request clears it. A request that stays high therefore does not bring back a bit that the host has cleared.

Top module: `prio_irq_combiner`

## Requirements
- R1: While reset is active and after reset is released, status, mask, `ipl_o` and `vec_o` are all zero.
- R2: A rising edge on a request sets that source's status bit. Source index to bit: 0 floppy→7, 1 keyboard/mouse→3, 2 power→2, 3 Ethernet receive→9, 4 Ethernet transmit→10, 5 SCSI→12, 6 timer→5, 7 serial→17, 8 Ethernet transmit DMA→28, 9 Ethernet receive DMA→27, 10 SCSI DMA→26, 11 sound→23, 12 serial DMA→21.
- R3: A falling edge on a request clears that source's status bit.
- R4: With `bus_we` high, `bus_sel_mask`=0 overwrites all 32 status bits and `bus_sel_mask`=1 overwrites the mask. `bus_rdata` shows status when `bus_sel_mask`=0 and mask when it is 1.
- R5: A bit is pending only when both its status bit and its mask bit are 1. With nothing pending `ipl_o` is 0. Status bits that no source owns (for example bit 0) never raise the level.
- R6: Sources 0–6 form level 3, source 7 forms level 5 and sources 8–12 form level 6. `ipl_o` gives the highest level that has a pending bit.
- R7: `vec_o` is 27 when `ipl_o` is 3, 29 when it is 5, 30 when it is 6, and 0 when it is 0.
- R8: `ipl_o` and `vec_o` are registered. They follow a change in status or mask one clock later, so they follow a request edge two clocks later.
- R9: A strobe on `scsi_ctl_we` loads status bit 26 with `scsi_ctl_wdata[4]`.
- R10: In any one cycle, a request edge sets or clears its bit ahead of a host status write and ahead of the control strobe.
- R11: A request held steady leaves its status bit as the host last wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 13 | Peripheral request levels, indexed as in R2 |
| bus_we | input | 1 | Host register write strobe |
| bus_sel_mask | input | 1 | Register select: 0 status, 1 mask |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Selected register contents |
| scsi_ctl_we | input | 1 | Disk-interface control write strobe |
| scsi_ctl_wdata | input | 8 | Control write data; bit 4 drives status bit 26 |
| ipl_o | output | 3 | Processor interrupt priority level |
| vec_o | output | 8 | Autovector number for `ipl_o` |

## Verification
A wrong bit mapping or a lost edge shows up on `bus_rdata` one clock after the request changes. The same fault shows up on `ipl_o` and `vec_o` one clock later, as a level that is missing or wrong. The bench raises each source alone and checks both the status word and the group level. This catches a source placed in the wrong bit or the wrong group. Write-precedence faults appear only when two writers hit the same cycle, so the bench lines up a request edge with a host write and with a control strobe. It then reads back which writer won. A wrong pipeline depth is caught by sampling the level exactly one clock after the status bit becomes visible.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned NSRC        = 13;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned FORCE_BIT   = 26;
  localparam int unsigned CTL_SEL_BIT = 4;

  localparam logic [7:0] VEC_LVL3 = 8'd27;
  localparam logic [7:0] VEC_LVL5 = 8'd29;
  localparam logic [7:0] VEC_LVL6 = 8'd30;

  // status bit owned by each source index
  function automatic int unsigned src_bit(input int unsigned idx);
    case (idx)
      0:       return 7;
      1:       return 3;
      2:       return 2;
      3:       return 9;
      4:       return 10;
      5:       return 12;
      6:       return 5;
      7:       return 17;
      8:       return 28;
      9:       return 27;
      10:      return 26;
      11:      return 23;
      default: return 21;
    endcase
  endfunction

  // priority group of each source index
  function automatic logic [2:0] src_lvl(input int unsigned idx);
    if (idx <= 6)      return 3'd3;
    else if (idx == 7) return 3'd5;
    else               return 3'd6;
  endfunction

  // status bits that belong to one priority group
  function automatic logic [WORD_W-1:0] group_mask(input logic [2:0] lvl);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NSRC; i++) begin
      if (src_lvl(i) == lvl) m = m | (WORD_W'(1) << src_bit(i));
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_edge_track.sv
module irq_edge_track #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;
  logic         prev_en;

  always_comb begin
    prev_d  = req_i;
    prev_en = (req_i != prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= prev_d;
  end

  assign rise_o = req_i & ~prev_q;
  assign fall_o = ~req_i & prev_q;

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned N  = NSRC,
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  rise_i,
  input  logic [N-1:0]  fall_i,
  input  logic          st_we_i,
  input  logic          mk_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ctl_we_i,
  input  logic          ctl_val_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] mask_o
);

  localparam int unsigned IW = $clog2(DW);

  logic [DW-1:0] set_v;
  logic [DW-1:0] clr_v;
  logic [DW-1:0] st_d;
  logic [DW-1:0] st_q;
  logic          st_en;
  logic [DW-1:0] mk_q;

  // gather per-source edges into word-wide set and clear vectors
  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int unsigned i = 0; i < N; i++) begin
      set_v[IW'(src_bit(i))] = set_v[IW'(src_bit(i))] | rise_i[i];
      clr_v[IW'(src_bit(i))] = clr_v[IW'(src_bit(i))] | fall_i[i];
    end
  end

  // host write lowest, control strobe next, request edges win
  always_comb begin
    st_d = st_q;
    if (st_we_i)  st_d = wdata_i;
    if (ctl_we_i) st_d[FORCE_BIT] = ctl_val_i;
    st_d  = (st_d & ~clr_v) | set_v;
    st_en = st_we_i | ctl_we_i | (|set_v) | (|clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mk_q <= '0;
    else if (mk_we_i) mk_q <= wdata_i;
  end

  assign status_o = st_q;
  assign mask_o   = mk_q;

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_agg_pkg::*;
#(
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    pend_i,
  output logic [2:0]       ipl_o,
  output logic [VEC_W-1:0] vec_o
);

  localparam logic [DW-1:0] M_L3 = group_mask(3'd3);
  localparam logic [DW-1:0] M_L5 = group_mask(3'd5);
  localparam logic [DW-1:0] M_L6 = group_mask(3'd6);

  logic [2:0]       ipl_d, ipl_q;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic             out_en;

  always_comb begin
    if (|(pend_i & M_L6)) begin
      ipl_d = 3'd6;
      vec_d = VEC_W'(VEC_LVL6);
    end else if (|(pend_i & M_L5)) begin
      ipl_d = 3'd5;
      vec_d = VEC_W'(VEC_LVL5);
    end else if (|(pend_i & M_L3)) begin
      ipl_d = 3'd3;
      vec_d = VEC_W'(VEC_LVL3);
    end else begin
      ipl_d = 3'd0;
      vec_d = '0;
    end
    out_en = (ipl_d != ipl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipl_q <= '0;
      vec_q <= '0;
    end else if (out_en) begin
      ipl_q <= ipl_d;
      vec_q <= vec_d;
    end
  end

  assign ipl_o = ipl_q;
  assign vec_o = vec_q;

endmodule

// File: rtl/prio_irq_combiner.sv
module prio_irq_combiner
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = NSRC,
  parameter int unsigned DATA_W  = WORD_W,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned CTL_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               bus_we,
  input  logic               bus_sel_mask,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               scsi_ctl_we,
  input  logic [CTL_W-1:0]   scsi_ctl_wdata,
  output logic [2:0]         ipl_o,
  output logic [VEC_W-1:0]   vec_o
);

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] fall;
  logic [DATA_W-1:0]  status_q;
  logic [DATA_W-1:0]  mask_q;
  logic [DATA_W-1:0]  pend;
  logic               unused_ctl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  irq_edge_track #(.N(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .req_i  (src_req),
    .rise_o (rise),
    .fall_o (fall)
  );

  irq_status_bank #(.N(NUM_SRC), .DW(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rise_i    (rise),
    .fall_i    (fall),
    .st_we_i   (bus_we & ~bus_sel_mask),
    .mk_we_i   (bus_we & bus_sel_mask),
    .wdata_i   (bus_wdata),
    .ctl_we_i  (scsi_ctl_we),
    .ctl_val_i (scsi_ctl_wdata[CTL_SEL_BIT]),
    .status_o  (status_q),
    .mask_o    (mask_q)
  );

  assign pend = status_q & mask_q;

  irq_level_enc #(.DW(DATA_W), .VEC_W(VEC_W)) u_enc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pend_i (pend),
    .ipl_o  (ipl_o),
    .vec_o  (vec_o)
  );

  assign bus_rdata  = bus_sel_mask ? mask_q : status_q;
  assign unused_ctl = ^{scsi_ctl_wdata[CTL_W-1:CTL_SEL_BIT+1],
                        scsi_ctl_wdata[CTL_SEL_BIT-1:0]};

endmodule

// File: rtl/prio_irq_combiner_chk.sv
module prio_irq_combiner_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = NSRC,
  parameter int unsigned DATA_W  = WORD_W,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned CTL_W   = 8
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NUM_SRC-1:0] src_req,
  input logic               bus_we,
  input logic               bus_sel_mask,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               scsi_ctl_we,
  input logic [CTL_W-1:0]   scsi_ctl_wdata,
  input logic [DATA_W-1:0]  status_q,
  input logic [DATA_W-1:0]  mask_q,
  input logic [2:0]         ipl_o,
  input logic [VEC_W-1:0]   vec_o
);

  localparam logic [DATA_W-1:0] CHK_L6 = group_mask(3'd6);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int unsigned B = src_bit(i);
    // R2
    src_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(src_req[i]) |=> status_q[B]);
    // R3
    src_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $fell(src_req[i]) |=> !status_q[B]);
  end

  // R4
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_sel_mask) |=> (mask_q == $past(bus_wdata)));

  // R5
  idle_lvl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((status_q & mask_q) == '0) |=> (ipl_o == 3'd0));

  // R6
  top_lvl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(status_q & mask_q & CHK_L6)) |=> (ipl_o == 3'd6));

  // R7
  vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((ipl_o == 3'd0) && (vec_o == '0)) || ((ipl_o == 3'd3) && (vec_o == VEC_W'(27))) ||
    ((ipl_o == 3'd5) && (vec_o == VEC_W'(29))) || ((ipl_o == 3'd6) && (vec_o == VEC_W'(30))));

  // R9
  ctl_force_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (scsi_ctl_we && $stable(src_req[10])) |=>
      (status_q[FORCE_BIT] == $past(scsi_ctl_wdata[CTL_SEL_BIT])));

endmodule

bind prio_irq_combiner prio_irq_combiner_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .VEC_W(VEC_W), .CTL_W(CTL_W)
) u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .src_req        (src_req),
  .bus_we         (bus_we),
  .bus_sel_mask   (bus_sel_mask),
  .bus_wdata      (bus_wdata),
  .scsi_ctl_we    (scsi_ctl_we),
  .scsi_ctl_wdata (scsi_ctl_wdata),
  .status_q       (status_q),
  .mask_q         (mask_q),
  .ipl_o          (ipl_o),
  .vec_o          (vec_o)
);

// File: tb/prio_irq_combiner_tb.sv
`timescale 1ns/1ps
module prio_irq_combiner_tb;

  typedef struct {
    int          kind;   // 0: {ipl,vec}  1: bus_rdata
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] src_req;
  logic        bus_we;
  logic        bus_sel_mask;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        scsi_ctl_we;
  logic [7:0]  scsi_ctl_wdata;
  logic [2:0]  ipl_o;
  logic [7:0]  vec_o;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  item_t sb_q[$];

  // bit position and group per source index, taken from R2 and R6
  int bitpos [13] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};

  always #2.5 clk = ~clk;

  prio_irq_combiner u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .src_req        (src_req),
    .bus_we         (bus_we),
    .bus_sel_mask   (bus_sel_mask),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .scsi_ctl_we    (scsi_ctl_we),
    .scsi_ctl_wdata (scsi_ctl_wdata),
    .ipl_o          (ipl_o),
    .vec_o          (vec_o)
  );

  function automatic int lvl_of(input int idx);
    if (idx <= 6) return 3;
    if (idx == 7) return 5;
    return 6;
  endfunction

  function automatic int vec_of(input int lvl);
    case (lvl)
      3: return 27;
      5: return 29;
      6: return 30;
      default: return 0;
    endcase
  endfunction

  // ---------------- driver side ----------------
  task automatic exp_out(input int lvl, input string req);
    item_t it;
    it.kind = 0;
    it.exp  = 32'((lvl << 8) | vec_of(lvl));
    it.req  = req;
    sb_q.push_back(it);
  endtask

  task automatic exp_rd_now(input logic [31:0] val, input string req);
    item_t it;
    it.kind = 1;
    it.exp  = val;
    it.req  = req;
    sb_q.push_back(it);
  endtask

  task automatic exp_rd(input logic sel, input logic [31:0] val, input string req);
    @(negedge clk);
    bus_sel_mask = sel;
    exp_rd_now(val, req);
  endtask

  task automatic host_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    bus_we       = 1'b1;
    bus_sel_mask = sel;
    bus_wdata    = d;
    @(negedge clk);
    bus_we       = 1'b0;
    bus_sel_mask = 1'b0;
  endtask

  task automatic ctl_wr(input logic [7:0] d);
    @(negedge clk);
    scsi_ctl_we    = 1'b1;
    scsi_ctl_wdata = d;
    @(negedge clk);
    scsi_ctl_we    = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_src(input logic [12:0] v);
    @(negedge clk);
    src_req = v;
    settle();
  endtask

  // ---------------- monitor side ----------------
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = (it.kind == 0) ? {21'd0, ipl_o, vec_o} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%08h expected=%08h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n          = 1'b0;
    src_req        = '0;
    bus_we         = 1'b0;
    bus_sel_mask   = 1'b0;
    bus_wdata      = '0;
    scsi_ctl_we    = 1'b0;
    scsi_ctl_wdata = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    exp_out(0, "R1");
    exp_rd(1'b0, 32'h0, "R1");
    exp_rd(1'b1, 32'h0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_out(0, "R1");
    exp_rd(1'b0, 32'h0, "R1");

    // R4 mask write and readback
    host_wr(1'b1, 32'hFFFF_FFFF);
    exp_rd(1'b1, 32'hFFFF_FFFF, "R4");

    // R6 / R7 stacking of groups
    set_src(13'h0001);
    exp_out(3, "R6_R7");
    exp_rd(1'b0, 32'h0000_0080, "R2");
    set_src(13'h0081);
    exp_out(5, "R6_R7");
    exp_rd(1'b0, 32'h0002_0080, "R2");
    set_src(13'h0881);
    exp_out(6, "R6_R7");
    exp_rd(1'b0, 32'h0082_0080, "R2");

    // R3 falling edges clear
    set_src(13'h0081);
    exp_out(5, "R3");
    exp_rd(1'b0, 32'h0002_0080, "R3");
    set_src(13'h0000);
    exp_out(0, "R3");
    exp_rd(1'b0, 32'h0, "R3");

    // R5 masking
    host_wr(1'b1, 32'h0);
    set_src(13'h0020);
    exp_out(0, "R5");
    exp_rd(1'b0, 32'h0000_1000, "R5");
    host_wr(1'b1, 32'h0000_1000);
    settle();
    exp_out(3, "R5");

    // R4 / R5 / R11: overwrite status with an unmapped bit, request held high
    host_wr(1'b1, 32'hFFFF_FFFF);
    host_wr(1'b0, 32'h0000_0001);
    settle();
    settle();
    exp_out(0, "R5");
    exp_rd(1'b0, 32'h0000_0001, "R11");

    // R10: request edge beats a host status write in the same cycle
    @(negedge clk);
    bus_we       = 1'b1;
    bus_sel_mask = 1'b0;
    bus_wdata    = 32'h0;
    src_req      = 13'h0030;
    @(negedge clk);
    bus_we = 1'b0;
    settle();
    exp_rd(1'b0, 32'h0000_0400, "R10");
    exp_out(3, "R10");

    // R9 control strobe forces bit 26
    host_wr(1'b0, 32'h0);
    ctl_wr(8'h10);
    settle();
    exp_rd(1'b0, 32'h0400_0000, "R9");
    exp_out(6, "R9");
    ctl_wr(8'hEF);
    settle();
    exp_rd(1'b0, 32'h0, "R9");
    exp_out(0, "R9");

    // R10: request edge beats the control strobe
    @(negedge clk);
    scsi_ctl_we    = 1'b1;
    scsi_ctl_wdata = 8'h00;
    src_req        = 13'h0430;
    @(negedge clk);
    scsi_ctl_we = 1'b0;
    settle();
    exp_rd(1'b0, 32'h0400_0000, "R10");
    exp_out(6, "R10");

    // R8 one-cycle output register
    host_wr(1'b0, 32'h0);
    settle();
    exp_out(0, "R8");
    @(negedge clk);
    bus_sel_mask = 1'b0;
    src_req      = 13'h0434;
    @(posedge clk);
    @(negedge clk);
    exp_rd_now(32'h0000_0004, "R8");
    exp_out(0, "R8");
    @(posedge clk);
    @(negedge clk);
    exp_out(3, "R8");

    // R2 / R6 every source alone
    set_src(13'h0000);
    host_wr(1'b0, 32'h0);
    for (int i = 0; i < 13; i++) begin
      set_src(13'(1 << i));
      exp_rd_now(32'(1) << bitpos[i], "R2");
      exp_out(lvl_of(i), "R6");
      set_src(13'h0000);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule